// File: doc/BRIEF.md
# Programmable Crosspoint Switch Fabric

This block is the configurable wiring of a logic cluster together with a set of four-sided switch points. A crossbar joins every source wire to every destination wire through its own on/off crosspoint. The sources are the outputs of the logic elements and the signals entering the cluster. The destinations are the inputs of the logic elements and the signals leaving the cluster. One source can reach any number of destinations at once. A destination that is claimed by more than one source is reported as a configuration error and held at 0.

Next to the crossbar sits one switch point per routing track. Each switch point is told which of its four sides (north, east, south, west) is the driver. It forwards that side's signal to any chosen subset of the other three sides. Together the switch points form a small switch block in which track `t` connects only to track `t` on each side.

All configuration lives in one shift chain that is loaded one bit per clock while a load enable is held. The chain keeps its contents until it is loaded again. The routing path itself is purely combinational: once loaded, outputs follow inputs in the same cycle.

Top module: `xfab_top`

## Requirements
- R1: After reset every crosspoint is open, every switch point drives north with an empty forward mask, all routed outputs read 0 and every conflict flag is low.
- R2: While `cfg_en_i` is high, each rising clock edge moves chain bit i to bit i+1 and loads `cfg_bit_i` into bit 0. The chain holds SRC*DST + 6*TRACKS bits. Crosspoint (destination d, source s) is bit d*SRC+s. The six bits of track t start at SRC*DST + 6*t, with the driving side in the lower two bits and the forward mask in the upper four, one mask bit per side.
- R3: While `cfg_en_i` is low the chain holds its value and `cfg_bit_i` has no effect on any output.
- R4: A destination with exactly one closed crosspoint carries that source. Sources 0..N_LE-1 are the logic-element outputs and the following N_CIN sources are the cluster inputs. Destinations 0..N_LE*K_IN-1 are the logic-element inputs and the following N_COUT destinations are the cluster outputs.
- R5: One source whose crosspoints to several destinations are closed drives all of those destinations at once.
- R6: A logic-element output can be routed to a cluster output.
- R7: A destination with no closed crosspoint reads 0.
- R8: A destination with two or more closed crosspoints raises its conflict flag and reads 0. The flag is low otherwise.
- R9: In a switch point, the side codes are 0 north, 1 east, 2 south and 3 west. Each non-driving side whose mask bit is set outputs the driving side's input. A non-driving side whose mask bit is clear outputs 0.
- R10: The driving side's own output reads 0 whatever its mask bit holds.
- R11: Switch points are independent per track. Track t uses `sp_in_i`/`sp_out_o` bits t*4+side.
- R12: Routing has no clock latency: a change on a source reaches its destinations in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low clear of the configuration chain |
| cfg_en_i | input | 1 | Shift enable for the configuration chain |
| cfg_bit_i | input | 1 | Serial configuration data |
| le_out_i | input | N_LE | Logic-element outputs (crossbar sources) |
| clu_in_i | input | N_CIN | Cluster inputs (crossbar sources) |
| le_in_o | output | N_LE*K_IN | Logic-element inputs (crossbar destinations) |
| clu_out_o | output | N_COUT | Cluster outputs (crossbar destinations) |
| conflict_o | output | N_LE*K_IN+N_COUT | Per-destination multiple-source flag |
| sp_in_i | input | TRACKS*4 | Switch-point side inputs, index track*4+side |
| sp_out_o | output | TRACKS*4 | Switch-point side outputs, index track*4+side |

## Verification
Fan-out and conflict detection can act on the same source in the same cycle. This happens when one source feeds several destinations and one of those destinations also has a second source closed. The bench loads such a pattern and drives every source high. It then judges that the clean destinations follow the source with their flags low, while the shared destination alone reads 0 with its flag raised. Loading and routing also overlap: the bench shifts one extra bit into a loaded chain and checks that the route moves to the neighbouring source at once.

// File: rtl/xfab_pkg.sv
package xfab_pkg;

  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  localparam int SP_CFG_W = 6;

  // per-track switch-point setup: forward mask above, driving side below
  typedef struct packed {
    logic [3:0] fwd;
    side_e      drv;
  } sp_cfg_t;

  // outputs of one switch point for a given setup and side inputs
  function automatic logic [3:0] sp_route(sp_cfg_t c, logic [3:0] ins);
    logic [3:0] o;
    o = '0;
    for (int k = 0; k < 4; k++) begin
      if ((k != int'(c.drv)) && c.fwd[k]) o[k] = ins[c.drv];
    end
    return o;
  endfunction

endpackage

// File: rtl/xfab_cfg_chain.sv
module xfab_cfg_chain #(
  parameter int LEN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (shift_en) cfg_q <= {cfg_q[LEN-2:0], din};
  end

endmodule

// File: rtl/xfab_xbar.sv
module xfab_xbar #(
  parameter int SRC = 8,
  parameter int DST = 8
) (
  input  logic [SRC-1:0]     src_i,
  input  logic [SRC*DST-1:0] xp_i,
  output logic [DST-1:0]     dst_o,
  output logic [DST-1:0]     conflict_o
);

  // {conflict, value} for one destination column
  function automatic logic [1:0] resolve_col(logic [SRC-1:0] en, logic [SRC-1:0] v);
    logic seen;
    logic multi;
    seen  = 1'b0;
    multi = 1'b0;
    for (int s = 0; s < SRC; s++) begin
      if (en[s]) begin
        if (seen) multi = 1'b1;
        seen = 1'b1;
      end
    end
    return {multi, (~multi) & (|(en & v))};
  endfunction

  for (genvar d = 0; d < DST; d++) begin : g_col
    logic [1:0] res;
    assign res           = resolve_col(xp_i[d*SRC +: SRC], src_i);
    assign dst_o[d]      = res[0];
    assign conflict_o[d] = res[1];
  end

endmodule

// File: rtl/xfab_swpt.sv
module xfab_swpt
  import xfab_pkg::*;
(
  input  sp_cfg_t    cfg_i,
  input  logic [3:0] side_i,
  output logic [3:0] side_o
);

  assign side_o = sp_route(cfg_i, side_i);

endmodule

// File: rtl/xfab_top.sv
module xfab_top
  import xfab_pkg::*;
#(
  parameter int N_LE   = 4,
  parameter int K_IN   = 4,
  parameter int N_CIN  = 4,
  parameter int N_COUT = 2,
  parameter int TRACKS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_en_i,
  input  logic                          cfg_bit_i,
  input  logic [N_LE-1:0]               le_out_i,
  input  logic [N_CIN-1:0]              clu_in_i,
  output logic [N_LE*K_IN-1:0]          le_in_o,
  output logic [N_COUT-1:0]             clu_out_o,
  output logic [N_LE*K_IN+N_COUT-1:0]   conflict_o,
  input  logic [TRACKS*4-1:0]           sp_in_i,
  output logic [TRACKS*4-1:0]           sp_out_o
);

  localparam int SRC     = N_LE + N_CIN;
  localparam int N_LEIN  = N_LE * K_IN;
  localparam int DST     = N_LEIN + N_COUT;
  localparam int XB_BITS = SRC * DST;
  localparam int SP_BITS = TRACKS * SP_CFG_W;
  localparam int CFG_LEN = XB_BITS + SP_BITS;

  logic [CFG_LEN-1:0] cfg_q;
  logic [SRC-1:0]     src_vec;
  logic [DST-1:0]     dst_vec;

  xfab_cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en_i),
    .din      (cfg_bit_i),
    .cfg_q    (cfg_q)
  );

  assign src_vec = {clu_in_i, le_out_i};

  xfab_xbar #(.SRC(SRC), .DST(DST)) u_xbar (
    .src_i      (src_vec),
    .xp_i       (cfg_q[XB_BITS-1:0]),
    .dst_o      (dst_vec),
    .conflict_o (conflict_o)
  );

  assign le_in_o   = dst_vec[N_LEIN-1:0];
  assign clu_out_o = dst_vec[DST-1:N_LEIN];

  for (genvar t = 0; t < TRACKS; t++) begin : g_trk
    sp_cfg_t sc;
    assign sc = cfg_q[XB_BITS + t*SP_CFG_W +: SP_CFG_W];
    xfab_swpt u_sp (
      .cfg_i  (sc),
      .side_i (sp_in_i[t*4 +: 4]),
      .side_o (sp_out_o[t*4 +: 4])
    );
  end

endmodule

// File: rtl/xfab_checker.sv
module xfab_checker #(
  parameter int CFG_LEN = 8,
  parameter int XB_BITS = 4,
  parameter int DST     = 2,
  parameter int TRACKS  = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_en_i,
  input logic               cfg_bit_i,
  input logic [CFG_LEN-1:0] cfg_q,
  input logic [DST-1:0]     dst_vec,
  input logic [DST-1:0]     conflict_o,
  input logic [TRACKS*4-1:0] sp_in_i,
  input logic [TRACKS*4-1:0] sp_out_o
);

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en_i |=> $stable(cfg_q)) else $error("chain moved without enable"); // R3

  AST_CFG_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en_i |=> (cfg_q[0] == $past(cfg_bit_i))) else $error("serial bit lost"); // R2

  AST_CFG_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en_i |=> (cfg_q[1] == $past(cfg_q[0]))) else $error("chain did not advance"); // R2

  AST_CONFLICT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_o & dst_vec) == '0) else $error("conflicting destination not held low"); // R8

  for (genvar t = 0; t < TRACKS; t++) begin : g_t
    logic [1:0] drv;
    logic [3:0] fwd;
    assign drv = cfg_q[XB_BITS + t*6 +: 2];
    assign fwd = cfg_q[XB_BITS + t*6 + 2 +: 4];

    AST_SP_DRV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sp_out_o[t*4 + int'(drv)]) else $error("driving side echoed"); // R10

    for (genvar k = 0; k < 4; k++) begin : g_k
      AST_SP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv != 2'(k)) && !fwd[k]) |-> !sp_out_o[t*4+k]) else $error("masked side driven"); // R9
      AST_SP_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv != 2'(k)) && fwd[k]) |-> (sp_out_o[t*4+k] == sp_in_i[t*4 + int'(drv)]))
        else $error("forward side wrong"); // R9
    end
  end

endmodule

bind xfab_top xfab_checker #(
  .CFG_LEN (CFG_LEN),
  .XB_BITS (XB_BITS),
  .DST     (DST),
  .TRACKS  (TRACKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_en_i   (cfg_en_i),
  .cfg_bit_i  (cfg_bit_i),
  .cfg_q      (cfg_q),
  .dst_vec    (dst_vec),
  .conflict_o (conflict_o),
  .sp_in_i    (sp_in_i),
  .sp_out_o   (sp_out_o)
);

// File: tb/xfab_top_test.sv
module xfab_top_test;

  localparam int N_LE = 4, K_IN = 4, N_CIN = 4, N_COUT = 2, TRACKS = 3;
  localparam int SRC = N_LE + N_CIN;
  localparam int NLI = N_LE * K_IN;
  localparam int DST = NLI + N_COUT;
  localparam int XB  = SRC * DST;
  localparam int LEN = XB + 6 * TRACKS;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cfg_en = 1'b0, cfg_bit = 1'b0;
  logic [N_LE-1:0] le_out = '0;
  logic [N_CIN-1:0] clu_in = '0;
  logic [NLI-1:0] le_in;
  logic [N_COUT-1:0] clu_out;
  logic [DST-1:0] conflict;
  logic [TRACKS*4-1:0] sp_in = '0, sp_out;

  xfab_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_en_i(cfg_en), .cfg_bit_i(cfg_bit),
    .le_out_i(le_out), .clu_in_i(clu_in), .le_in_o(le_in), .clu_out_o(clu_out),
    .conflict_o(conflict), .sp_in_i(sp_in), .sp_out_o(sp_out)
  );

  int n_run = 0, n_fail = 0;
  logic [LEN-1:0] cfg_m = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int xp(input int d, input int s);
    return d * SRC + s;
  endfunction

  task automatic load(input logic [LEN-1:0] v);
    @(negedge clk);
    cfg_en = 1'b1;
    for (int i = LEN - 1; i >= 0; i--) begin
      cfg_bit = v[i];
      @(negedge clk);
    end
    cfg_en = 1'b0;
    cfg_m  = v;
  endtask

  function automatic logic [3:0] sp_cfg(input int drv, input logic [3:0] mask);
    return {mask, 2'(drv)};
  endfunction

  // independent model of all outputs from the bench's view of the chain
  task automatic check_model(input string tag);
    logic [SRC-1:0] s;
    logic [DST-1:0] ed, ec;
    logic [TRACKS*4-1:0] es;
    #1;
    s = {clu_in, le_out};
    for (int d = 0; d < DST; d++) begin
      int cnt = 0;
      logic v = 1'b0;
      for (int k = 0; k < SRC; k++)
        if (cfg_m[xp(d, k)]) begin cnt++; v = s[k]; end
      ed[d] = (cnt == 1) ? v : 1'b0;
      ec[d] = (cnt > 1);
    end
    for (int t = 0; t < TRACKS; t++) begin
      int base = XB + 6 * t;
      int dv = int'(cfg_m[base +: 2]);
      for (int k = 0; k < 4; k++)
        es[t*4+k] = (k != dv && cfg_m[base+2+k]) ? sp_in[t*4+dv] : 1'b0;
    end
    chk({tag, " dst"}, 64'({clu_out, le_in}), 64'(ed));
    chk({tag, " conflict"}, 64'(conflict), 64'(ec));
    chk({tag, " sp"}, 64'(sp_out), 64'(es));
  endtask

  task automatic t_reset;
    le_out = '1; clu_in = '1; sp_in = '1;
    #1;
    chk("R1 dst after reset", 64'({clu_out, le_in}), 64'd0);
    chk("R1 conflict after reset", 64'(conflict), 64'd0);
    chk("R1 sp after reset", 64'(sp_out), 64'd0);
  endtask

  task automatic t_straight;
    logic [LEN-1:0] v = '0;
    for (int i = 0; i < N_LE; i++) v[xp(i*K_IN, i)] = 1'b1;
    for (int c = 0; c < N_CIN; c++) v[xp(c*K_IN+1, N_LE+c)] = 1'b1;
    load(v);
    le_out = 4'b0001; clu_in = 4'b0000;
    #1 chk("R12 same-cycle route", 64'(le_in[0]), 64'd1);
    le_out = 4'b0000;
    #1 chk("R12 same-cycle release", 64'(le_in[0]), 64'd0);
    le_out = 4'b1010; clu_in = 4'b0101; check_model("R4 pattern A");
    le_out = 4'b0101; clu_in = 4'b1110; check_model("R4 pattern B");
    le_out = 4'b1111; clu_in = 4'b0011; check_model("R4 pattern C");
    chk("R4 cluster input 2 at LE input 9", 64'(le_in[9]), 64'd0);
  endtask

  task automatic t_fanout;
    logic [LEN-1:0] v = '0;
    for (int d = 0; d < NLI; d++) v[xp(d, 2)] = 1'b1;
    load(v);
    le_out = 4'b0100; clu_in = '1;
    #1 chk("R5 fan-out high", 64'(le_in), 64'hFFFF);
    chk("R7 undriven cluster outputs", 64'(clu_out), 64'd0);
    le_out = 4'b1011;
    #1 chk("R5 fan-out low", 64'(le_in), 64'd0);
  endtask

  task automatic t_cluster_out;
    logic [LEN-1:0] v = '0;
    v[xp(NLI, 3)] = 1'b1;
    v[xp(NLI+1, 1)] = 1'b1;
    load(v);
    le_out = 4'b1000;
    #1 chk("R6 LE out to cluster out", 64'(clu_out), 64'b01);
    le_out = 4'b0010;
    #1 chk("R6 LE out to cluster out", 64'(clu_out), 64'b10);
    check_model("R6 model");
  endtask

  task automatic t_conflict;
    logic [LEN-1:0] v = '0;
    v[xp(0, 0)] = 1'b1; v[xp(0, 5)] = 1'b1; v[xp(1, 0)] = 1'b1;
    load(v);
    le_out = '1; clu_in = '1;
    #1 chk("R8 shared destination value", 64'(le_in[1:0]), 64'b10);
    chk("R8 conflict flags", 64'(conflict), 64'd1);
    check_model("R8 model");
  endtask

  task automatic t_hold;
    logic [DST-1:0] snap;
    le_out = 4'b0110; clu_in = 4'b1001;
    #1 snap = {clu_out, le_in};
    for (int i = 0; i < 10; i++) begin
      cfg_bit = i[0];
      @(negedge clk);
    end
    chk("R3 config ignores serial input", 64'({clu_out, le_in}), 64'(snap));
    check_model("R3 model");
  endtask

  task automatic t_shift;
    logic [LEN-1:0] v = '0;
    v[xp(0, 3)] = 1'b1;
    load(v);
    le_out = 4'b1000; clu_in = '0;
    #1 chk("R2 before extra shift", 64'(le_in[0]), 64'd1);
    @(negedge clk); cfg_en = 1'b1; cfg_bit = 1'b0;
    @(negedge clk); cfg_en = 1'b0;
    cfg_m = cfg_m << 1;
    #1 chk("R2 old source dropped", 64'(le_in[0]), 64'd0);
    clu_in = 4'b0001;
    #1 chk("R2 route moved to next source", 64'(le_in[0]), 64'd1);
    check_model("R2 model");
  endtask

  task automatic t_switch;
    logic [LEN-1:0] v = '0;
    v[XB +: 6]      = {4'b0111, 2'd0};
    v[XB + 6 +: 6]  = {4'b1111, 2'd3};
    v[XB + 12 +: 6] = {4'b0001, 2'd2};
    load(v);
    sp_in = 12'b0000_0000_0001;
    #1 chk("R9 N to E and S", 64'(sp_out[3:0]), 64'b0110);
    chk("R10 driving side quiet", 64'(sp_out[0]), 64'd0);
    chk("R11 other tracks idle", 64'(sp_out[11:4]), 64'd0);
    sp_in = 12'b0100_1000_0000;
    #1 chk("R9 W to all", 64'(sp_out[7:4]), 64'b0111);
    chk("R9 S to N", 64'(sp_out[11:8]), 64'b0001);
    chk("R11 track 0 idle", 64'(sp_out[3:0]), 64'd0);
    sp_in = 12'b1011_0111_1110; check_model("R11 mixed");
    sp_in = 12'b1111_1111_1111; check_model("R9 all high");
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_straight;
    t_fanout;
    t_cluster_out;
    t_conflict;
    t_hold;
    t_shift;
    t_switch;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule